// File: doc/BRIEF.md
# Divide-Initialization Execution Slice

This block is one execution slice of a 32-bit processor datapath that handles the register-to-register divide-preparation group. It does not divide. For each accepted instruction it takes a dividend `a`, a divisor `b` and the current upper word of the destination register pair. It then pre-positions the dividend across a low/high result pair, so that a later iterative divide-step unit can start from it. In the same step it predicts whether the coming division will overflow.

The overflow rules depend on the variant and on a revision select input. The byte and halfword forms use a magnitude comparison on the older revision and a divisor-is-zero test on the newer one. The slice also computes a per-byte parity word. Results and status flags are registered on the clock edge where a valid strobe meets a matching primary opcode. A sticky overflow flag collects every overflow until it is cleared.

Top module: `divinit_unit`

## Requirements
- R1: The slice acts only when `valid_i` is high and `prim_op_i` equals 8'h4B. Otherwise, results, V, AV and `illegal_o` do not change, and `illegal_o` is 0 on the next cycle.
- R2: Secondary code 3'b000 (signed) sets the low result to `a` and fills every bit of the high result with bit 31 of `a`.
- R3: For the signed code, V is set when `b` is zero, or when `b` is 32'hFFFFFFFF and `a` is 32'h80000000. Otherwise V is clear.
- R4: Secondary code 3'b001 (unsigned) sets the low result to `a` and the high result to zero. V is set only when `b` is zero.
- R5: Secondary code 3'b010 (unsigned byte) sets the low result to `a` shifted left by 24 and the high result to `a` shifted right by 8, with zero fill.
- R6: Secondary code 3'b011 (unsigned halfword) sets the low result to `a` shifted left by 16 and the high result to `a` shifted right by 16, with zero fill.
- R7: For codes 3'b010 and 3'b011 with `rev_new_i`=0, V is set when the magnitude of `hi_prev_i` is at least the magnitude of `b`. Each magnitude is the two's-complement absolute value read as an unsigned 32-bit number.
- R8: For codes 3'b010 and 3'b011 with `rev_new_i`=1, V is set only when `b` is zero.
- R9: Every code from 3'b000 to 3'b011 clears AV and loads V. SV becomes (SV and not `sv_clr_i`) OR the new V. Without a divide-init, `sv_clr_i` alone clears SV on the edge.
- R10: Secondary code 3'b100 (parity) writes the even-parity bit of byte n of `a` (the XOR of its 8 bits) into low result bit 8n, zeros every other bit of both results, and leaves V and AV unchanged.
- R11: Secondary codes 3'b101, 3'b110 and 3'b111 leave the results, V and AV unchanged and raise `illegal_o` for one cycle.
- R12: A synchronous reset clears both results, V, SV, AV and `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction strobe |
| prim_op_i | input | 8 | Primary opcode field |
| sec_op_i | input | 3 | Secondary opcode field |
| rev_new_i | input | 1 | 1 selects newer revision overflow rules |
| sv_clr_i | input | 1 | Clears the sticky overflow flag |
| a_i | input | 32 | Dividend / parity source |
| b_i | input | 32 | Divisor |
| hi_prev_i | input | 32 | Current upper word of the destination pair |
| res_lo_o | output | 32 | Low result word |
| res_hi_o | output | 32 | High result word |
| v_o | output | 1 | Overflow flag |
| sv_o | output | 1 | Sticky overflow flag |
| av_o | output | 1 | Advance overflow flag |
| illegal_o | output | 1 | Unknown secondary code seen |

## Verification
The embedded properties check the following on every cycle:
- the signed high-word fill and the zero high word of the unsigned and parity forms;
- that nothing moves when the primary opcode mismatches or the secondary code is unknown;
- that a rising V always comes with SV;
- that SV persists without a clear.

Only the bench's scenarios can show the following:
- the exact shifted words of the byte and halfword forms;
- the boundary cases of the overflow predictions, such as minimum integer over minus one, equal magnitudes, and the most negative `hi_prev_i` under the older revision;
- the per-byte parity bit positions;
- the interaction of a clear with a simultaneous overflow.

// File: rtl/divinit_pkg.sv
package divinit_pkg;
   typedef enum logic [2:0] {
      DOP_SDIV  = 3'b000,
      DOP_UDIV  = 3'b001,
      DOP_UBYTE = 3'b010,
      DOP_UHALF = 3'b011,
      DOP_PAR   = 3'b100
   } dop_e;

   localparam int unsigned LAST_DIVINIT = 3;
   localparam int unsigned LAST_KNOWN   = 4;
endpackage

// File: rtl/divinit_shape.sv
module divinit_shape #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o
);
   import divinit_pkg::*;
   localparam int unsigned NBYTES  = DATA_W / 8;
   localparam int unsigned BYTE_SH = DATA_W - 8;
   localparam int unsigned HALF_SH = DATA_W / 2;

   logic [DATA_W-1:0] par_word;

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_par
         assign par_word[8*g]         = ^a_i[8*g +: 8];
         assign par_word[8*g+1 +: 7]  = '0;
      end
   endgenerate

   always_comb begin
      lo_o = '0;
      hi_o = '0;
      case (dop_e'(op_i))
         DOP_SDIV: begin
            lo_o = a_i;
            hi_o = {DATA_W{a_i[DATA_W-1]}};
         end
         DOP_UDIV: begin
            lo_o = a_i;
            hi_o = '0;
         end
         DOP_UBYTE: begin
            lo_o = a_i << BYTE_SH;
            hi_o = a_i >> 8;
         end
         DOP_UHALF: begin
            lo_o = a_i << HALF_SH;
            hi_o = a_i >> HALF_SH;
         end
         DOP_PAR: begin
            lo_o = par_word;
            hi_o = '0;
         end
         default: begin
            lo_o = '0;
            hi_o = '0;
         end
      endcase
   end
endmodule

// File: rtl/divinit_ovf.sv
module divinit_ovf #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]        op_i,
   input  logic              rev_new_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] hi_prev_i,
   output logic              ovf_o
);
   import divinit_pkg::*;
   localparam logic [DATA_W-1:0] MIN_INT = {1'b1, {(DATA_W-1){1'b0}}};

   logic              b_zero;
   logic [DATA_W-1:0] mag_hi;
   logic [DATA_W-1:0] mag_b;
   logic              mag_ovf;

   assign b_zero  = (b_i == '0);
   assign mag_hi  = hi_prev_i[DATA_W-1] ? (~hi_prev_i + 1'b1) : hi_prev_i;
   assign mag_b   = b_i[DATA_W-1] ? (~b_i + 1'b1) : b_i;
   assign mag_ovf = (mag_hi >= mag_b);

   always_comb begin
      case (dop_e'(op_i))
         DOP_SDIV:  ovf_o = b_zero || ((&b_i) && (a_i == MIN_INT));
         DOP_UDIV:  ovf_o = b_zero;
         DOP_UBYTE,
         DOP_UHALF: ovf_o = rev_new_i ? b_zero : mag_ovf;
         default:   ovf_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/divinit_unit.sv
module divinit_unit #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PRIM_W   = 8,
   parameter logic [PRIM_W-1:0] PRIM_CODE = 8'h4B
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [PRIM_W-1:0] prim_op_i,
   input  logic [2:0]        sec_op_i,
   input  logic              rev_new_i,
   input  logic              sv_clr_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] hi_prev_i,
   output logic [DATA_W-1:0] res_lo_o,
   output logic [DATA_W-1:0] res_hi_o,
   output logic              v_o,
   output logic              sv_o,
   output logic              av_o,
   output logic              illegal_o
);
   import divinit_pkg::*;

   initial begin
      if (DATA_W % 16 != 0 || DATA_W < 16)
         $error("divinit_unit: DATA_W must be a multiple of 16");
   end

   logic              hit, known, is_div;
   logic [DATA_W-1:0] nx_lo, nx_hi;
   logic              nx_ovf;

   assign hit    = valid_i && (prim_op_i == PRIM_CODE);
   assign known  = (32'(sec_op_i) <= LAST_KNOWN);
   assign is_div = (32'(sec_op_i) <= LAST_DIVINIT);

   divinit_shape #(.DATA_W(DATA_W)) u_shape (
      .op_i (sec_op_i),
      .a_i  (a_i),
      .lo_o (nx_lo),
      .hi_o (nx_hi)
   );

   divinit_ovf #(.DATA_W(DATA_W)) u_ovf (
      .op_i      (sec_op_i),
      .rev_new_i (rev_new_i),
      .a_i       (a_i),
      .b_i       (b_i),
      .hi_prev_i (hi_prev_i),
      .ovf_o     (nx_ovf)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_lo_o  <= '0;
         res_hi_o  <= '0;
         v_o       <= 1'b0;
         sv_o      <= 1'b0;
         av_o      <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         illegal_o <= hit && !known;
         if (hit && known) begin
            res_lo_o <= nx_lo;
            res_hi_o <= nx_hi;
         end
         if (hit && is_div) begin
            v_o  <= nx_ovf;
            av_o <= 1'b0;
            sv_o <= (sv_o && !sv_clr_i) || nx_ovf;
         end else if (sv_clr_i) begin
            sv_o <= 1'b0;
         end
      end
   end

   p_signed_fill_r2: assert property (@(posedge clk) disable iff (rst)
      (hit && sec_op_i == DOP_SDIV) |=> (res_hi_o == {DATA_W{$past(a_i[DATA_W-1])}}));

   p_unsigned_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (hit && sec_op_i == DOP_UDIV) |=> (res_hi_o == '0 && res_lo_o == $past(a_i)));

   p_parity_hi_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (hit && sec_op_i == DOP_PAR) |=> (res_hi_o == '0 && $stable(v_o)));

   p_miss_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (!hit) |=> ($stable(res_lo_o) && $stable(res_hi_o) && $stable(v_o) && !illegal_o));

   p_illegal_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (hit && !known) |=> (illegal_o && $stable(res_lo_o) && $stable(res_hi_o) && $stable(v_o)));

   p_v_with_sv_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(v_o) |-> sv_o);

   p_sv_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (sv_o && !sv_clr_i) |=> sv_o);
endmodule

// File: tb/divinit_unit_tb.sv
`timescale 1ns/1ps
module divinit_unit_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid_i;
   logic [7:0]  prim_op_i;
   logic [2:0]  sec_op_i;
   logic        rev_new_i;
   logic        sv_clr_i;
   logic [31:0] a_i, b_i, hi_prev_i;
   logic [31:0] res_lo_o, res_hi_o;
   logic        v_o, sv_o, av_o, illegal_o;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_lo, m_hi;
   logic        m_v, m_sv, m_av, m_ill;

   always #2.5 clk = ~clk;

   divinit_unit u_dut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .prim_op_i(prim_op_i),
      .sec_op_i(sec_op_i), .rev_new_i(rev_new_i), .sv_clr_i(sv_clr_i),
      .a_i(a_i), .b_i(b_i), .hi_prev_i(hi_prev_i),
      .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .v_o(v_o), .sv_o(sv_o),
      .av_o(av_o), .illegal_o(illegal_o)
   );

   function automatic logic [31:0] mag(input logic [31:0] x);
      longint s;
      s = (x >= 32'h8000_0000) ? longint'(x) - 64'sd4294967296 : longint'(x);
      if (s < 0) s = -s;
      return s[31:0];
   endfunction

   task automatic model_step();
      logic ov;
      int   code;
      code = int'(sec_op_i);
      m_ill = 1'b0;
      if (!(valid_i && prim_op_i == 8'h4B)) begin
         if (sv_clr_i) m_sv = 1'b0;
         return;
      end
      if (code > 4) begin
         m_ill = 1'b1;
         if (sv_clr_i) m_sv = 1'b0;
         return;
      end
      ov = 1'b0;
      case (code)
         0: begin
            m_lo = a_i;
            m_hi = (a_i >= 32'h8000_0000) ? 32'hFFFF_FFFF : 32'h0;
            ov = (b_i == 0) || (b_i == 32'hFFFF_FFFF && a_i == 32'h8000_0000);
         end
         1: begin m_lo = a_i; m_hi = 0; ov = (b_i == 0); end
         2, 3: begin
            if (code == 2) begin
               m_lo = a_i * 32'd16777216;
               m_hi = a_i / 32'd256;
            end else begin
               m_lo = a_i * 32'd65536;
               m_hi = a_i / 32'd65536;
            end
            ov = rev_new_i ? (b_i == 0) : (mag(hi_prev_i) >= mag(b_i));
         end
         default: begin
            m_hi = 0;
            m_lo = 0;
            for (int n = 0; n < 4; n++) begin
               int ones = 0;
               for (int k = 0; k < 8; k++) ones += int'(a_i[8*n+k]);
               m_lo[8*n] = (ones % 2 == 1);
            end
         end
      endcase
      if (code <= 3) begin
         m_v  = ov;
         m_av = 1'b0;
         m_sv = (m_sv && !sv_clr_i) || ov;
      end else if (sv_clr_i) begin
         m_sv = 1'b0;
      end
   endtask

   task automatic compare(input string req);
      checks++;
      if (res_lo_o !== m_lo || res_hi_o !== m_hi || v_o !== m_v ||
          sv_o !== m_sv || av_o !== m_av || illegal_o !== m_ill) begin
         errors++;
         $display("FAIL %s: actual lo=%h hi=%h v=%b sv=%b av=%b ill=%b expected lo=%h hi=%h v=%b sv=%b av=%b ill=%b",
                  req, res_lo_o, res_hi_o, v_o, sv_o, av_o, illegal_o,
                  m_lo, m_hi, m_v, m_sv, m_av, m_ill);
      end
   endtask

   task automatic op(input string req, input logic vld, input logic [7:0] p,
                     input logic [2:0] s, input logic rev, input logic clr,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] h);
      @(negedge clk);
      valid_i = vld; prim_op_i = p; sec_op_i = s; rev_new_i = rev;
      sv_clr_i = clr; a_i = a; b_i = b; hi_prev_i = h;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
      valid_i = 1'b0; sv_clr_i = 1'b0;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; valid_i = 0; prim_op_i = 0; sec_op_i = 0; rev_new_i = 0;
      sv_clr_i = 0; a_i = 0; b_i = 0; hi_prev_i = 0;
      m_lo = 0; m_hi = 0; m_v = 0; m_sv = 0; m_av = 0; m_ill = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R12 reset");
      rst = 1'b0;

      op("R2 signed positive", 1, 8'h4B, 3'd0, 0, 0, 32'h1234_5678, 32'd7, 0);
      op("R2 signed negative", 1, 8'h4B, 3'd0, 0, 0, 32'h8765_4321, 32'd3, 0);
      op("R3 signed b zero", 1, 8'h4B, 3'd0, 0, 0, 32'h5, 32'h0, 0);
      op("R3 signed min by minus one", 1, 8'h4B, 3'd0, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
      op("R3 signed min by one", 1, 8'h4B, 3'd0, 0, 0, 32'h8000_0000, 32'h1, 0);
      op("R4 unsigned nonzero", 1, 8'h4B, 3'd1, 0, 0, 32'hDEAD_BEEF, 32'h9, 0);
      op("R4 unsigned b zero", 1, 8'h4B, 3'd1, 1, 0, 32'hDEAD_BEEF, 32'h0, 0);
      op("R5 byte shape", 1, 8'h4B, 3'd2, 1, 0, 32'hA1B2_C3D4, 32'h3, 0);
      op("R6 half shape", 1, 8'h4B, 3'd3, 1, 0, 32'hA1B2_C3D4, 32'h3, 0);
      op("R7 byte old below", 1, 8'h4B, 3'd2, 0, 0, 32'h1, 32'hFFFF_FFF9, 32'd5);
      op("R7 byte old equal", 1, 8'h4B, 3'd2, 0, 0, 32'h1, 32'd9, 32'hFFFF_FFF7);
      op("R7 half old min hi", 1, 8'h4B, 3'd3, 0, 0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000);
      op("R7 half old zero both", 1, 8'h4B, 3'd3, 0, 0, 32'h1, 32'h0, 32'h0);
      op("R8 byte new large hi", 1, 8'h4B, 3'd2, 1, 1, 32'h1, 32'h1, 32'hFFFF_0000);
      op("R8 half new b zero", 1, 8'h4B, 3'd3, 1, 0, 32'h1, 32'h0, 32'h0);
      op("R9 sticky after clean op", 1, 8'h4B, 3'd1, 0, 0, 32'h1, 32'h1, 0);
      op("R9 clear alone", 0, 8'h4B, 3'd1, 0, 1, 32'h1, 32'h0, 0);
      op("R9 clear with overflow", 1, 8'h4B, 3'd1, 0, 1, 32'h1, 32'h0, 0);
      op("R10 parity pattern", 1, 8'h4B, 3'd4, 0, 0, 32'h01FF_0380, 32'h0, 0);
      op("R10 parity all ones", 1, 8'h4B, 3'd4, 0, 0, 32'hFFFF_FFFF, 32'h0, 0);
      op("R11 code five", 1, 8'h4B, 3'd5, 0, 0, 32'h1234, 32'h0, 0);
      op("R11 code seven", 1, 8'h4B, 3'd7, 0, 0, 32'h1234, 32'h0, 0);
      op("R1 wrong primary", 1, 8'h4A, 3'd0, 0, 0, 32'hFFFF_FFFF, 32'h0, 0);
      op("R1 no strobe", 0, 8'h4B, 3'd7, 0, 0, 32'hFFFF_FFFF, 32'h0, 0);

      for (int i = 0; i < 300; i++) begin
         logic [2:0]  s;
         logic [31:0] b;
         s = 3'($urandom_range(0, 7));
         b = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
         op("R1 R9 mixed", ($urandom_range(0, 7) != 0),
            ($urandom_range(0, 5) == 0) ? 8'h4C : 8'h4B, s,
            1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0),
            $urandom, b, $urandom);
      end

      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      m_lo = 0; m_hi = 0; m_v = 0; m_sv = 0; m_av = 0; m_ill = 0;
      @(negedge clk);
      compare("R12 reset again");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule